// File: doc/BRIEF.md
# Chunk-Granular Scan-Code Queue with Rollback

This block sits between the key-event source and the device-side serial transmitter. Key events arrive as chunks: a make code is one byte, and a break code or a multi-byte sequence is two or more bytes, with the final byte flagged. The queue stores bytes in arrival order and hands them to the transmitter one at a time. A chunk's storage is released only when the transmitter reports that the chunk's final byte has gone out.

If the host interrupts a transfer, the transmitter raises `abort`. The read cursor then returns to the first byte of the oldest unreleased chunk, so the whole chunk is sent again. While the host holds the bus off, nothing is consumed and the data stays queued. An incoming chunk is kept only if every one of its bytes fits. Otherwise the whole chunk is thrown away, so a partial code is never stored.

With `MOUSE_MODE` set, the block keeps only the newest packet. Committing a packet discards all older data, including a packet that was partly sent.

Top module: `scan_chunk_queue`

## Requirements
- R1: The queue holds at most `DEPTH` bytes (default 16, a power of two). `occupancy` reports how many committed bytes have not yet been released, and it never exceeds `DEPTH`.
- R2: Bytes come out in the order they were written. `rd_data` and `rd_last` show the byte at the read cursor. `rd_last` is 1 exactly on the final byte of a chunk. `rd_valid` is 1 whenever committed bytes remain past the cursor.
- R3: Each byte of an incoming chunk is checked against the space left (committed bytes plus bytes already staged for this chunk). If any byte of the chunk does not fit, the whole chunk is discarded, and `chunk_dropped` is 1 for the single cycle after its final byte is presented. Otherwise `chunk_dropped` is 0.
- R4: The bytes of a chunk are neither readable nor counted in `occupancy` until the cycle after its final byte (`wr_last` = 1) is accepted.
- R5: `byte_done` while `rd_valid` is 1 moves the cursor on by one byte. When that byte has `rd_last` = 1, the chunk's bytes are released and `occupancy` drops by the chunk length. `byte_done` while `rd_valid` is 0 has no effect.
- R6: `abort` returns the cursor to the first byte of the oldest unreleased chunk and releases nothing. When `abort` and `byte_done` arrive together, `abort` wins.
- R7: While neither `byte_done` nor `abort` is asserted, the queued bytes and the cursor stay unchanged for any number of cycles. New chunks may still be appended.
- R8: With `MOUSE_MODE` = 1, committing a packet discards all older committed bytes, including a partly sent packet. The cursor moves to the first byte of the new packet, and `occupancy` becomes the new packet's length.
- R9: After reset, `rd_valid`, `occupancy` and `chunk_dropped` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A chunk byte is presented |
| wr_data | input | DW | Byte value |
| wr_last | input | 1 | Presented byte ends its chunk |
| rd_valid | output | 1 | A byte is available at the cursor |
| rd_data | output | DW | Byte at the cursor |
| rd_last | output | 1 | Byte at the cursor ends its chunk |
| byte_done | input | 1 | Transmitter finished sending the cursor byte |
| abort | input | 1 | Transmitter was interrupted; resend current chunk |
| occupancy | output | AW+1 | Committed, unreleased byte count |
| chunk_dropped | output | 1 | One-cycle pulse: last chunk discarded for lack of room |

## Verification
The bench mixes random aborts with long stretches where nothing is consumed, so the queue is driven to full and chunks arrive that overrun it by one byte. A design that let part of such a chunk in would later emit a fragment with no end marker. A design that freed a chunk per byte would fail after an abort in the middle of a chunk: the first bytes would be missing on the resend. Oversized chunks and an abort in the same cycle as `byte_done` are also exercised. In mouse mode, the bench replaces a queued packet and a partly sent one. A design that did not discard the older data would show stale bytes at `rd_data`.

// File: rtl/scan_chunk_queue.sv
module scan_chunk_queue #(
  parameter int DEPTH      = 16,
  parameter int DW         = 8,
  parameter bit MOUSE_MODE = 1'b0,
  localparam int AW        = $clog2(DEPTH),
  localparam int PW        = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_last,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  input  logic          byte_done,
  input  logic          abort,
  output logic [PW-1:0] occupancy,
  output logic          chunk_dropped
);

  logic [DW:0]   mem [DEPTH];
  logic [PW-1:0] tail_q, head_c, head_s, stage_n;
  logic          stage_bad;

  wire [PW-1:0] used   = tail_q - head_c;
  wire [PW:0]   need   = {1'b0, used} + {1'b0, stage_n} + (PW+1)'(1);
  wire          fits   = need <= (PW+1)'(DEPTH);
  wire          wr_ok  = wr_valid && !stage_bad && fits;
  wire          commit = wr_ok && wr_last;
  wire          drop   = wr_valid && wr_last && !wr_ok;
  wire          replace = MOUSE_MODE && commit;
  wire [PW-1:0] wr_ptr = tail_q + stage_n;
  wire [DW:0]   cur    = mem[head_s[AW-1:0]];
  wire          take   = byte_done && rd_valid && !abort;

  assign rd_valid  = head_s != tail_q;
  assign rd_data   = cur[DW-1:0];
  assign rd_last   = cur[DW];
  assign occupancy = used;

  always_ff @(posedge clk)
    if (wr_ok) mem[wr_ptr[AW-1:0]] <= {wr_last, wr_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_n   <= '0;
      stage_bad <= 1'b0;
    end else if (wr_valid && wr_last) begin
      stage_n   <= '0;
      stage_bad <= 1'b0;
    end else if (wr_ok) begin
      stage_n   <= stage_n + PW'(1);
    end else if (wr_valid) begin
      stage_bad <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail_q        <= '0;
      head_c        <= '0;
      head_s        <= '0;
      chunk_dropped <= 1'b0;
    end else begin
      chunk_dropped <= drop;
      if (commit) tail_q <= wr_ptr + PW'(1);
      if (replace) begin
        head_c <= tail_q;
        head_s <= tail_q;
      end else if (abort) begin
        head_s <= head_c;
      end else if (take) begin
        head_s <= head_s + PW'(1);
        if (rd_last) head_c <= head_s + PW'(1);
      end
    end
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= PW'(DEPTH)); // R1

  AST_CURSOR_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_q - head_s) <= (tail_q - head_c)); // R2

  AST_DROP_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> $stable(tail_q)); // R3

  AST_STAGE_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_last && !replace) |=> $stable(tail_q)); // R4

  AST_MID_NO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !rd_last && !replace) |=> $stable(head_c)); // R5

  AST_ABORT_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !replace) |=> (head_s == $past(head_c)) && $stable(head_c)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_done && !abort && !replace) |=> $stable(head_s) && $stable(head_c)); // R7

  AST_MOUSE_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    replace |=> (head_s == head_c) && (head_c == $past(tail_q))); // R8

  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rst_n |=> !rd_valid && occupancy == '0 && !chunk_dropped); // R9

endmodule

// File: tb/tb_scan_chunk_queue.sv
module tb_scan_chunk_queue;
  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int PW    = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          wr_valid = 0, wr_last = 0, byte_done = 0, abort = 0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_valid, rd_last, chunk_dropped;
  logic [DW-1:0] rd_data;
  logic [PW-1:0] occupancy;

  logic          m_wv = 0, m_wl = 0, m_done = 0, m_ab = 0;
  logic [DW-1:0] m_wd = '0;
  logic          m_rv, m_rl, m_drop;
  logic [DW-1:0] m_rd;
  logic [PW-1:0] m_occ;

  scan_chunk_queue #(.DEPTH(DEPTH), .DW(DW), .MOUSE_MODE(1'b0)) dut (
    .clk, .rst_n, .wr_valid, .wr_data, .wr_last, .rd_valid, .rd_data, .rd_last,
    .byte_done, .abort, .occupancy, .chunk_dropped);

  scan_chunk_queue #(.DEPTH(DEPTH), .DW(DW), .MOUSE_MODE(1'b1)) dut_m (
    .clk, .rst_n, .wr_valid(m_wv), .wr_data(m_wd), .wr_last(m_wl),
    .rd_valid(m_rv), .rd_data(m_rd), .rd_last(m_rl), .byte_done(m_done),
    .abort(m_ab), .occupancy(m_occ), .chunk_dropped(m_drop));

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  logic [DW-1:0] mq[$];
  bit            ml[$];
  logic [DW-1:0] sq[$];
  int  spec = 0;
  bit  sbad = 0;
  bit  exp_drop = 0;
  int  clen = 1, cpos = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_occ();
    return mq.size();
  endfunction

  task automatic check_kb();
    bit v = spec < mq.size();
    chk("R2 rd_valid", rd_valid, v);
    if (v) begin
      chk("R2 rd_data", rd_data, mq[spec]);
      chk("R2 rd_last", rd_last, ml[spec]);
    end
    chk("R1 occupancy", occupancy, exp_occ());
    chk("R3 chunk_dropped", chunk_dropped, exp_drop);
  endtask

  task automatic step(input bit wv, input logic [7:0] wd, input bit wl,
                      input bit dn, input bit ab);
    int sz = mq.size();
    bit fit;
    exp_drop = 0;
    if (wv) begin
      fit = !sbad && (sz + sq.size() + 1 <= DEPTH);
      if (fit) sq.push_back(wd); else sbad = 1;
    end
    if (ab) spec = 0;
    else if (dn && spec < mq.size()) begin
      if (ml[spec]) begin
        for (int i = 0; i <= spec; i++) begin
          void'(mq.pop_front());
          void'(ml.pop_front());
        end
        spec = 0;
      end else spec++;
    end
    if (wv && wl) begin
      if (sbad) exp_drop = 1;
      else for (int i = 0; i < sq.size(); i++) begin
        mq.push_back(sq[i]);
        ml.push_back(i == sq.size() - 1);
      end
      sq.delete();
      sbad = 0;
    end
    wr_valid = wv; wr_data = wd; wr_last = wl; byte_done = dn; abort = ab;
  endtask

  task automatic rand_cycle(input int done_pct, input int ab_pct);
    bit wv = ($urandom % 100) < 40;
    bit wl = 0;
    logic [7:0] wd = 8'($urandom);
    if (wv) begin
      wl = (cpos == clen - 1);
      if (wl) begin
        cpos = 0;
        clen = (($urandom % 20) == 0) ? 17 : 1 + ($urandom % 3);
      end else cpos++;
    end
    step(wv, wd, wl, ($urandom % 100) < done_pct, ($urandom % 100) < ab_pct);
  endtask

  task automatic mouse_step(input bit wv, input logic [7:0] wd, input bit wl, input bit dn);
    m_wv = wv; m_wd = wd; m_wl = wl; m_done = dn; m_ab = 0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R9 rd_valid", rd_valid, 0);
    chk("R9 occupancy", occupancy, 0);
    chk("R9 chunk_dropped", chunk_dropped, 0);
    rst_n = 1;

    // R4: staged bytes invisible before end marker
    step(1, 8'he0, 0, 0, 0); @(negedge clk); check_kb();
    chk("R4 hidden occupancy", occupancy, 0);
    step(1, 8'h12, 1, 0, 0); @(negedge clk); check_kb();
    // R6: abort after first byte resends whole chunk; abort beats byte_done
    step(0, 0, 0, 1, 0); @(negedge clk); check_kb();
    step(0, 0, 0, 1, 1); @(negedge clk); check_kb();
    chk("R6 rewound data", rd_data, 8'he0);
    // R5: finish chunk, then byte_done on empty ignored
    step(0, 0, 0, 1, 0); @(negedge clk); check_kb();
    step(0, 0, 0, 1, 0); @(negedge clk); check_kb();
    chk("R5 freed", occupancy, 0);
    step(0, 0, 0, 1, 0); @(negedge clk); check_kb();
    // R3: oversized chunk dropped whole
    for (int i = 0; i < 17; i++) begin
      step(1, 8'(i), i == 16, 0, 0); @(negedge clk); check_kb();
    end
    chk("R3 oversized dropped", occupancy, 0);
    // R7: hold without consumption, fill to the brim
    for (int k = 0; k < 40; k++) begin
      rand_cycle(0, 0); @(negedge clk); check_kb();
    end
    for (int k = 0; k < 3000; k++) begin
      if ((k / 200) % 3 == 2) rand_cycle(0, 0);
      else rand_cycle(45, 6);
      @(negedge clk); check_kb();
    end
    step(0, 0, 0, 0, 0); @(negedge clk); check_kb();

    // R8: mouse mode keeps newest packet
    mouse_step(1, 8'ha1, 0, 0); mouse_step(1, 8'ha2, 0, 0); mouse_step(1, 8'ha3, 1, 0);
    chk("R8 first packet occ", m_occ, 3);
    mouse_step(1, 8'hb1, 0, 0); mouse_step(1, 8'hb2, 0, 0); mouse_step(1, 8'hb3, 1, 0);
    chk("R8 replaced occ", m_occ, 3);
    chk("R8 replaced data", m_rd, 8'hb1);
    mouse_step(0, 0, 0, 1);
    chk("R8 partial send", m_rd, 8'hb2);
    mouse_step(1, 8'hc1, 0, 0); mouse_step(1, 8'hc2, 0, 0); mouse_step(1, 8'hc3, 1, 0);
    mouse_step(0, 0, 0, 0);
    chk("R8 newest first", m_rd, 8'hc1);
    chk("R8 newest occ", m_occ, 3);
    chk("R8 valid", m_rv, 1);

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule